// File: doc/BRIEF.md
# Stored-Vector Go/No-Go Tester for a 4-bit Magnitude Comparator

The block tests a 4-bit magnitude comparator on a production line. It holds a short fixed suite of nine input patterns and, for each pattern, the response a good device must return. A single-cycle start pulse begins a run. The tester drives each 8-bit pattern onto the device inputs in a fixed order. It waits a programmable settle time and then samples the 3-bit response. It compares that response with the stored expectation.

A run ends at the first pattern whose response differs. The tester then reports fail, together with the 1-based position of the offending pattern. If all nine patterns match, it reports pass. The verdict stays on the outputs until the next accepted start. A start pulse that arrives during a run has no effect.

Top module: `cmp_vector_tester`

## Requirements
- R1: While reset is asserted, and after its release until a start, `busy`, `done`, `pass` and `fail` are low, `fail_idx` is 0 and `stim_o` is 0.
- R2: A start seen high while `busy` is low makes `busy` high and `done`, `pass`, `fail` and `fail_idx` zero on the next cycle. `stim_o` then carries the first pattern.
- R3: `stim_o[7:4]` is operand A and `stim_o[3:0]` is operand B, with bit 7 and bit 3 as the most significant bits. The patterns are applied in this order, in hex: 00, FF, 7F, D5, CB, EC, DE, 3E, BA.
- R4: `resp_i[2]` means A>B, `resp_i[1]` means A=B and `resp_i[0]` means A<B. The expected responses for the nine patterns, in order, are 010, 010, 001, 100, 100, 100, 001, 001, 100.
- R5: Each pattern stays on `stim_o` for SETTLE_CYCLES+1 cycles. The response is sampled on the (SETTLE_CYCLES+1)th rising edge after the pattern appeared.
- R6: When all nine responses match, the cycle after the last sample shows `busy` low, `done` and `pass` high and `fail` low. This is 9*(SETTLE_CYCLES+1) edges after the start edge.
- R7: On the first mismatch, the run stops at that sample. `busy` goes low, `done` and `fail` go high, and `fail_idx` shows the 1-based pattern position. No later pattern is applied, and `stim_o` keeps the failing pattern.
- R8: Once a run has ended, `done`, `pass`, `fail`, `fail_idx` and `stim_o` hold until the next start. A start while `busy` is high is ignored.
- R9: A device whose A=B output is stuck high is flagged at position 3. A device whose A>B output is stuck low is flagged at position 4.
- R10: A new start after a finished run clears the previous verdict and runs the suite again from the first pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the tester is idle |
| stim_o | output | 8 | Pattern driven to the device under test (A high nibble, B low nibble) |
| resp_i | input | 3 | Device response {A>B, A=B, A<B} |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High once a run has ended, until the next start |
| pass | output | 1 | Run ended with all patterns matching |
| fail | output | 1 | Run ended on a mismatch |
| fail_idx | output | 4 | 1-based position of the failing pattern, 0 otherwise |

## Verification
`busy` and the first pattern appear one cycle after the start edge. Each later pattern appears one cycle after the sample of the previous one. The verdict appears one cycle after the sample that decides it, SETTLE_CYCLES+1 edges after the pattern was applied. The bench keeps a behavioural model that advances on the same rising edge as the design and compares every output at the falling edge that follows, so each result is checked in exactly the cycle it becomes due. The length of each run is also counted in falling edges from the start pulse and compared with the count that R6 and R7 predict.

// File: rtl/vt_pkg.sv
package vt_pkg;
    localparam int unsigned NUM_VEC = 9;
    localparam int unsigned STIM_W  = 8;
    localparam int unsigned RESP_W  = 3;
    localparam int unsigned IDX_W   = $clog2(NUM_VEC + 1);

    typedef logic [STIM_W-1:0] stim_t;
    typedef logic [RESP_W-1:0] resp_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        logic  pass;
        logic  fail;
        idx_t  idx;
        idx_t  fidx;
        stim_t stim;
    } seq_t;
endpackage

// File: rtl/vt_suite_rom.sv
module vt_suite_rom
    import vt_pkg::*;
(
    input  idx_t  vec_idx,
    input  idx_t  sig_idx,
    output stim_t vec,
    output resp_t sig
);
    // stimulus: {a0..a3, b0..b3}, a0/b0 most significant
    always_comb begin
        case (vec_idx)
            idx_t'(0): vec = 8'h00;
            idx_t'(1): vec = 8'hFF;
            idx_t'(2): vec = 8'h7F;
            idx_t'(3): vec = 8'hD5;
            idx_t'(4): vec = 8'hCB;
            idx_t'(5): vec = 8'hEC;
            idx_t'(6): vec = 8'hDE;
            idx_t'(7): vec = 8'h3E;
            idx_t'(8): vec = 8'hBA;
            default:   vec = 8'h00;
        endcase
    end

    // signature: {gt, eq, lt}
    always_comb begin
        case (sig_idx)
            idx_t'(0): sig = 3'b010;
            idx_t'(1): sig = 3'b010;
            idx_t'(2): sig = 3'b001;
            idx_t'(3): sig = 3'b100;
            idx_t'(4): sig = 3'b100;
            idx_t'(5): sig = 3'b100;
            idx_t'(6): sig = 3'b001;
            idx_t'(7): sig = 3'b001;
            idx_t'(8): sig = 3'b100;
            default:   sig = 3'b000;
        endcase
    end
endmodule

// File: rtl/vt_settle_timer.sv
module vt_settle_timer #(
    parameter int unsigned CNT_W    = 2,
    parameter int unsigned LOAD_VAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CNT_W'(LOAD_VAL);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/vt_resp_cmp.sv
module vt_resp_cmp
    import vt_pkg::*;
(
    input  resp_t resp,
    input  resp_t sig,
    output logic  match
);
    assign match = (resp == sig);
endmodule

// File: rtl/cmp_vector_tester.sv
module cmp_vector_tester #(
    parameter int unsigned SETTLE_CYCLES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic [7:0]             stim_o,
    input  logic [2:0]             resp_i,
    output logic                   busy,
    output logic                   done,
    output logic                   pass,
    output logic                   fail,
    output logic [vt_pkg::IDX_W-1:0] fail_idx
);
    import vt_pkg::*;

    localparam int unsigned CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam idx_t LAST_IDX = idx_t'(NUM_VEC - 1);

    seq_t  st_d, st_q;
    idx_t  rom_addr;
    stim_t rom_vec;
    resp_t rom_sig;
    logic  settle_load;
    logic  settled;
    logic  resp_ok;

    assign rom_addr = st_q.busy ? idx_t'(st_q.idx + 1'b1) : '0;

    vt_suite_rom u_rom (
        .vec_idx (rom_addr),
        .sig_idx (st_q.idx),
        .vec     (rom_vec),
        .sig     (rom_sig)
    );

    vt_settle_timer #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settled)
    );

    vt_resp_cmp u_cmp (
        .resp  (resp_i),
        .sig   (rom_sig),
        .match (resp_ok)
    );

    always_comb begin
        st_d        = st_q;
        settle_load = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.done   = 1'b0;
                st_d.pass   = 1'b0;
                st_d.fail   = 1'b0;
                st_d.fidx   = '0;
                st_d.idx    = '0;
                st_d.stim   = rom_vec;
                settle_load = 1'b1;
            end
        end else if (settled) begin
            if (!resp_ok) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.fail = 1'b1;
                st_d.fidx = idx_t'(st_q.idx + 1'b1);
            end else if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.pass = 1'b1;
            end else begin
                st_d.idx    = idx_t'(st_q.idx + 1'b1);
                st_d.stim   = rom_vec;
                settle_load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stim_o   = st_q.stim;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign pass     = st_q.pass;
    assign fail     = st_q.fail;
    assign fail_idx = st_q.fidx;
endmodule

// File: rtl/vt_tester_chk.sv
module vt_tester_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] stim_o,
    input logic       busy,
    input logic       done,
    input logic       pass,
    input logic       fail,
    input logic [3:0] fail_idx
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && !pass && !fail));

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(fail_idx)));

    // R8
    idle_stim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(stim_o));

    // R7
    fail_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_idx >= 4'd1 && fail_idx <= 4'd9));
endmodule

bind cmp_vector_tester vt_tester_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stim_o   (stim_o),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .fail_idx (fail_idx)
);

// File: tb/cmp_vector_tester_tb.sv
module cmp_vector_tester_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] stim_o;
    logic [2:0] resp_i;
    logic       busy, done, pass, fail;
    logic [3:0] fail_idx;

    int mode = 0; // 0 good, 1 eq stuck high, 2 gt stuck low
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 1'b0;

    // model state
    bit       m_busy, m_done, m_pass, m_fail;
    int       m_idx, m_fidx, m_wait;
    logic [7:0] m_stim;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_vector_tester #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .stim_o (stim_o),
        .resp_i (resp_i), .busy (busy), .done (done), .pass (pass),
        .fail (fail), .fail_idx (fail_idx)
    );

    function automatic logic [7:0] pattern(int i);
        case (i)
            0: return 8'h00; 1: return 8'hFF; 2: return 8'h7F;
            3: return 8'hD5; 4: return 8'hCB; 5: return 8'hEC;
            6: return 8'hDE; 7: return 8'h3E; default: return 8'hBA;
        endcase
    endfunction

    function automatic logic [2:0] device(logic [7:0] s, int m);
        int a = int'(s[7:4]);
        int b = int'(s[3:0]);
        logic [2:0] r = {a > b, a == b, a < b};
        if (m == 1) r[1] = 1'b1;
        if (m == 2) r[2] = 1'b0;
        return r;
    endfunction

    always_comb resp_i = device(stim_o, mode);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
            m_idx = 0; m_fidx = 0; m_wait = 0; m_stim = 8'h00;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_done = 0; m_pass = 0; m_fail = 0; m_fidx = 0;
                m_idx = 0; m_stim = pattern(0); m_wait = SETTLE;
            end
        end else if (m_wait > 0) begin
            m_wait--;
        end else if (device(m_stim, mode) != device(m_stim, 0)) begin
            m_busy = 0; m_done = 1; m_fail = 1; m_fidx = m_idx + 1;
        end else if (m_idx == 8) begin
            m_busy = 0; m_done = 1; m_pass = 1;
        end else begin
            m_idx++; m_stim = pattern(m_idx); m_wait = SETTLE;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            check("R3 R5", "stim_o", int'(stim_o), int'(m_stim));
            check("R2", "busy", int'(busy), int'(m_busy));
            check("R6", "done", int'(done), int'(m_done));
            check("R4 R6", "pass", int'(pass), int'(m_pass));
            check("R7", "fail", int'(fail), int'(m_fail));
            check("R7", "fail_idx", int'(fail_idx), m_fidx);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    // one run; extra_start pulses start again mid-run
    task automatic run(int m, bit exp_pass, int exp_fidx, bit extra_start, string req);
        int n;
        @(negedge clk);
        mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check("R2", "busy after start", int'(busy), 1);
        check("R3", "first pattern", int'(stim_o), 8'h00);
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
            if (extra_start && n == 5) start = 1'b1;
            if (extra_start && n == 6) start = 1'b0;
        end
        check(req, "verdict pass", int'(pass), int'(exp_pass));
        check(req, "verdict fail", int'(fail), int'(!exp_pass));
        check(req, "fail_idx", int'(fail_idx), exp_fidx);
        if (exp_pass)
            check("R6", "run length", n, 9 * (SETTLE + 1) + 1);
        else begin
            check("R7", "run length", n, exp_fidx * (SETTLE + 1) + 1);
            check("R7", "stim held at failing pattern", int'(stim_o), int'(pattern(exp_fidx - 1)));
        end
        repeat (4) @(negedge clk);
        check("R8", "verdict held", int'({done, pass, fail}), int'({1'b1, exp_pass, !exp_pass}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "idle outputs in reset", int'({busy, done, pass, fail, fail_idx, stim_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle outputs after reset", int'({busy, done, pass, fail, fail_idx, stim_o}), 0);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        run(0, 1'b1, 0, 1'b0, "R4");
        run(1, 1'b0, 3, 1'b0, "R9");
        run(0, 1'b1, 0, 1'b1, "R10");
        run(2, 1'b0, 4, 1'b0, "R9");
        run(0, 1'b1, 0, 1'b0, "R10");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule